// File: doc/BRIEF.md
# Shadow Register File Tracker

This block sits between a command decoder and the live register file of a rendering engine. Each register write arrives as an index and a 32-bit argument. A mode register chooses what happens to the write. It can pass the argument through unchanged. It can record the argument into a second, shadow copy of the register file (plain track or track-with-filter; both behave the same here). Or it can replay, which discards the incoming argument and uses the value held in the shadow copy instead. The result of that choice is the effective argument. It is written to the live register only when it differs from what the live register already holds. In that case every dirty group the register belongs to is flagged, so that consumers rebuild only the state that really changed.

Writes enter over a valid/ready stream. The effective argument leaves over a one-deep valid/ready stream. An accepted write updates the live register, the shadow copy and the dirty vector at the accepting edge. The live file can be read at any time through a combinational read port. Software-side consumers acknowledge dirty groups through a clear vector.

Back-pressure rules: a write is accepted on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is high when the output slot is empty or is being drained in that same cycle. While `eff_valid` is high and `eff_ready` is low, `eff_idx` and `eff_arg` hold their values.

Top module: `shreg_tracker`

## Requirements
- R1: After reset the dirty vector is all ones, `eff_valid` is low, every live register reads zero, every shadow entry is zero and the mode is passthrough.
- R2: In passthrough (mode code 0) the effective argument equals the incoming argument and the shadow copy is left unchanged; a later replay of that index returns the old shadow value.
- R3: In track (code 1) and track-with-filter (code 2) the effective argument equals the incoming argument and that argument is also stored in the shadow copy at the written index.
- R4: In replay (code 3) the effective argument is the shadow value at the written index and the incoming argument has no effect.
- R5: When the effective argument equals the live register's current value, the live register is not written and no dirty bit is raised.
- R6: When the effective argument differs, the live register takes it and the dirty bits of its groups are set. Register i belongs to group g = i / (NREG/NGRP). An odd i also belongs to group NGRP-1-g.
- R7: A write to the mode register index (MODE_IDX, default 60) always uses the raw argument, whatever the mode, and is never recorded in the shadow copy. The new mode is taken from argument bits [1:0] and applies from the next write on.
- R8: Each set bit of `dirty_clr` clears that dirty bit on the next edge. When a clear and a change-driven set hit the same bit in one cycle, the set wins.
- R9: `wr_ready` is low while an effective result is held with `eff_ready` low. While it is held, `eff_idx` and `eff_arg` stay stable and no further write is accepted.
- R10: The effective result, the live register update and the dirty update all become visible on the first rising edge after the accepting edge... more precisely, they are visible in the cycle that directly follows the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write can be accepted |
| wr_idx | input | 8 | Register index of the write |
| wr_arg | input | 32 | Incoming argument |
| eff_valid | output | 1 | Effective result present |
| eff_ready | input | 1 | Consumer takes the effective result |
| eff_idx | output | 8 | Index of the effective result |
| eff_arg | output | 32 | Effective argument after mode handling |
| rd_idx | input | 8 | Live register read index |
| rd_data | output | 32 | Live register contents at rd_idx |
| dirty_clr | input | 16 | Dirty bits to clear |
| dirty | output | 16 | Per-group dirty flags |

## Verification
The dirty vector has two writers: the clear input and the change detector of an accepted write. Both can target the same group in the same cycle. The bench provokes this by driving `dirty_clr` on the same edge as a value-changing write to a register of that group, while also clearing a neighbouring group that is set beforehand. The result counts as correct only if the written group stays set and the neighbour is cleared. A second overlap, between a held output and a new write, is judged by checking that the held result does not move and that the live file still shows the old value at the stalled write's index.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [1:0] {
    MODE_PASS       = 2'd0,
    MODE_TRACK      = 2'd1,
    MODE_TRACK_FILT = 2'd2,
    MODE_REPLAY     = 2'd3
  } shmode_e;
endpackage

// File: rtl/shreg_grp_rom.sv
module shreg_grp_rom #(
  parameter int NREG = 256,
  parameter int NGRP = 16,
  localparam int IW  = $clog2(NREG),
  localparam int SPAN = NREG / NGRP
) (
  input  logic [IW-1:0]   idx,
  output logic [NGRP-1:0] mask
);
  logic [NGRP-1:0] rom [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_entry
    localparam int PRI = i / SPAN;
    localparam int SEC = NGRP - 1 - PRI;
    if (i % 2 == 1) begin : g_odd
      assign rom[i] = (NGRP'(1) << PRI) | (NGRP'(1) << SEC);
    end else begin : g_even
      assign rom[i] = NGRP'(1) << PRI;
    end
  end

  assign mask = rom[idx];
endmodule

// File: rtl/shreg_shadow.sv
module shreg_shadow
  import shreg_pkg::*;
#(
  parameter int NREG = 256,
  parameter int DW   = 32,
  parameter int MODE_IDX = 60,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] arg,
  input  shmode_e       mode,
  output logic [DW-1:0] eff
);
  logic [DW-1:0] shadow_q [NREG];
  logic is_mode;
  logic record;

  assign is_mode = (idx == IW'(MODE_IDX));
  assign record  = acc && !is_mode &&
                   (mode == MODE_TRACK || mode == MODE_TRACK_FILT);

  always_comb begin
    eff = arg;
    if (mode == MODE_REPLAY && !is_mode) eff = shadow_q[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) shadow_q[i] <= '0;
    end else if (record) begin
      shadow_q[idx] <= arg;
    end
  end

  // R3: a recorded write is held in the shadow copy afterwards
  p_record_r3: assert property (@(posedge clk) disable iff (!rst_n)
    record |=> shadow_q[$past(idx)] == $past(arg));

  // R7: the mode index never enters the shadow copy
  p_mode_unrecorded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_mode) |=> $stable(shadow_q[MODE_IDX]));
endmodule

// File: rtl/shreg_live.sv
module shreg_live
  import shreg_pkg::*;
#(
  parameter int NREG = 256,
  parameter int DW   = 32,
  parameter int NGRP = 16,
  parameter int MODE_IDX = 60,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic [IW-1:0]   idx,
  input  logic [DW-1:0]   eff,
  input  logic [1:0]      raw_mode,
  input  logic [NGRP-1:0] grp_mask,
  input  logic [NGRP-1:0] dirty_clr,
  input  logic [IW-1:0]   rd_idx,
  output logic [DW-1:0]   rd_data,
  output logic [NGRP-1:0] dirty,
  output shmode_e         mode
);
  logic [DW-1:0]   live_q [NREG];
  logic [DW-1:0]   cur;
  logic            changed;
  logic [NGRP-1:0] set_v;

  assign cur     = live_q[idx];
  assign changed = acc && (cur != eff);
  assign set_v   = changed ? grp_mask : '0;
  assign rd_data = live_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) live_q[i] <= '0;
    end else if (changed) begin
      live_q[idx] <= eff;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dirty <= {NGRP{1'b1}};
    else        dirty <= (dirty & ~dirty_clr) | set_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             mode <= MODE_PASS;
    else if (acc && idx == IW'(MODE_IDX))   mode <= shmode_e'(raw_mode);
  end

  // R5: no bit rises without a value change
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !changed |=> (dirty & ~$past(dirty)) == '0);

  // R6: a change sets all of its groups and lands in the live copy
  p_change_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    changed |=> ((dirty & $past(grp_mask)) == $past(grp_mask)) &&
                (live_q[$past(idx)] == $past(eff)));

  // R8: a clear without a same-cycle set drops the bit
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_clr != '0) |=> (dirty & $past(dirty_clr) & ~$past(set_v)) == '0);

  // R7: the mode follows the raw bits written to its index
  p_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && idx == IW'(MODE_IDX)) |=> mode == shmode_e'($past(raw_mode)));
endmodule

// File: rtl/shreg_tracker.sv
module shreg_tracker
  import shreg_pkg::*;
#(
  parameter int NREG = 256,
  parameter int DW   = 32,
  parameter int NGRP = 16,
  parameter int MODE_IDX = 60,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [IW-1:0]   wr_idx,
  input  logic [DW-1:0]   wr_arg,
  output logic            eff_valid,
  input  logic            eff_ready,
  output logic [IW-1:0]   eff_idx,
  output logic [DW-1:0]   eff_arg,
  input  logic [IW-1:0]   rd_idx,
  output logic [DW-1:0]   rd_data,
  input  logic [NGRP-1:0] dirty_clr,
  output logic [NGRP-1:0] dirty
);
  logic            acc;
  logic [DW-1:0]   eff_c;
  logic [NGRP-1:0] mask;
  shmode_e         mode;

  assign wr_ready = !eff_valid || eff_ready;
  assign acc      = wr_valid && wr_ready;

  shreg_grp_rom #(.NREG(NREG), .NGRP(NGRP)) u_rom (
    .idx (wr_idx),
    .mask(mask)
  );

  shreg_shadow #(.NREG(NREG), .DW(DW), .MODE_IDX(MODE_IDX)) u_shadow (
    .clk  (clk),
    .rst_n(rst_n),
    .acc  (acc),
    .idx  (wr_idx),
    .arg  (wr_arg),
    .mode (mode),
    .eff  (eff_c)
  );

  shreg_live #(.NREG(NREG), .DW(DW), .NGRP(NGRP), .MODE_IDX(MODE_IDX)) u_live (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .idx      (wr_idx),
    .eff      (eff_c),
    .raw_mode (wr_arg[1:0]),
    .grp_mask (mask),
    .dirty_clr(dirty_clr),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .dirty    (dirty),
    .mode     (mode)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_valid <= 1'b0;
      eff_idx   <= '0;
      eff_arg   <= '0;
    end else if (acc) begin
      eff_valid <= 1'b1;
      eff_idx   <= wr_idx;
      eff_arg   <= eff_c;
    end else if (eff_ready) begin
      eff_valid <= 1'b0;
    end
  end

  // R9: a stalled result holds still
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_valid && !eff_ready) |=> eff_valid && $stable(eff_arg) && $stable(eff_idx));

  // R10: an accepted write is presented on the next cycle
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> eff_valid && eff_idx == $past(wr_idx));

  // R2: passthrough hands the argument on untouched
  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == MODE_PASS) |=> eff_arg == $past(wr_arg));
endmodule

// File: tb/shreg_tracker_tb_top.sv
module shreg_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_idx = '0;
  logic [31:0] wr_arg = '0;
  logic        eff_valid;
  logic        eff_ready = 1'b1;
  logic [7:0]  eff_idx;
  logic [31:0] eff_arg;
  logic [7:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic [15:0] dirty_clr = '0;
  logic [15:0] dirty;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  shreg_tracker dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_arg(wr_arg),
    .eff_valid(eff_valid), .eff_ready(eff_ready), .eff_idx(eff_idx), .eff_arg(eff_arg),
    .rd_idx(rd_idx), .rd_data(rd_data), .dirty_clr(dirty_clr), .dirty(dirty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one write, result sampled on the cycle after the accepting edge (R10)
  task automatic wr(input logic [7:0] i, input logic [31:0] a);
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = i; wr_arg = a;
    @(negedge clk);
    wr_valid = 1'b0;
    rd_idx = i;
    #1;
  endtask

  task automatic clr(input logic [15:0] m);
    @(negedge clk);
    dirty_clr = m;
    @(negedge clk);
    dirty_clr = '0;
    #1;
  endtask

  task automatic t_reset;
    chk("R1 dirty", 32'(dirty), 32'h0000_FFFF);
    chk("R1 eff_valid", 32'(eff_valid), 32'd0);
    rd_idx = 8'h05; #1;
    chk("R1 live", rd_data, 32'd0);
  endtask

  task automatic t_pass;
    clr(16'hFFFF);
    chk("R8 clear all", 32'(dirty), 32'd0);
    wr(8'h05, 32'hA5A5_0001);
    chk("R2 eff_arg", eff_arg, 32'hA5A5_0001);
    chk("R10 eff_valid", 32'(eff_valid), 32'd1);
    chk("R10 eff_idx", 32'(eff_idx), 32'h05);
    chk("R6 live", rd_data, 32'hA5A5_0001);
    chk("R6 odd groups", 32'(dirty), 32'h0000_8001);
    clr(16'h0001);
    chk("R8 partial clear", 32'(dirty), 32'h0000_8000);
  endtask

  task automatic t_equal;
    clr(16'hFFFF);
    wr(8'h05, 32'hA5A5_0001);
    chk("R5 eff", eff_arg, 32'hA5A5_0001);
    chk("R5 no dirty", 32'(dirty), 32'd0);
  endtask

  task automatic t_modes;
    clr(16'hFFFF);
    wr(8'd60, 32'd1);
    chk("R7 mode raw", eff_arg, 32'd1);
    chk("R6 even group", 32'(dirty), 32'h0000_0008);
    wr(8'h20, 32'hB0B0_0000);
    chk("R3 track eff", eff_arg, 32'hB0B0_0000);
    wr(8'd60, 32'd2);
    wr(8'h21, 32'hC0C0_0001);
    chk("R3 filt eff", eff_arg, 32'hC0C0_0001);
    chk("R6 dirty", 32'(dirty), 32'h0000_200C);
    wr(8'd60, 32'd3);
    clr(16'hFFFF);
    wr(8'h20, 32'hDEAD_BEEF);
    chk("R4 replay track", eff_arg, 32'hB0B0_0000);
    chk("R4 live kept", rd_data, 32'hB0B0_0000);
    chk("R5 replay equal", 32'(dirty), 32'd0);
    wr(8'h21, 32'h1234_5678);
    chk("R4 replay filt", eff_arg, 32'hC0C0_0001);
    wr(8'h05, 32'h9999_9999);
    chk("R2 shadow untouched", eff_arg, 32'd0);
    chk("R6 live to zero", rd_data, 32'd0);
    chk("R6 dirty replay", 32'(dirty), 32'h0000_8001);
    wr(8'd60, 32'd4);
    chk("R7 raw in replay", eff_arg, 32'd4);
    wr(8'h20, 32'h7777_0000);
    chk("R7 back to pass", eff_arg, 32'h7777_0000);
  endtask

  task automatic t_collide;
    clr(16'hFFFF);
    wr(8'h30, 32'd9);
    chk("R6 group3", 32'(dirty), 32'h0000_0008);
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = 8'h10; wr_arg = 32'h55; dirty_clr = 16'h000A;
    @(negedge clk);
    wr_valid = 1'b0; dirty_clr = '0;
    #1;
    chk("R8 set wins", 32'(dirty), 32'h0000_0002);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    eff_ready = 1'b0;
    wr(8'h40, 32'h0000_1111);
    chk("R9 first eff", eff_arg, 32'h0000_1111);
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = 8'h42; wr_arg = 32'h0000_2222; rd_idx = 8'h42;
    #1;
    chk("R9 not ready", 32'(wr_ready), 32'd0);
    for (int k = 0; k < 3; k++) @(negedge clk);
    #1;
    chk("R9 held arg", eff_arg, 32'h0000_1111);
    chk("R9 held idx", 32'(eff_idx), 32'h40);
    chk("R9 stalled write", rd_data, 32'd0);
    eff_ready = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    #1;
    chk("R9 second eff", eff_arg, 32'h0000_2222);
    chk("R9 second live", rd_data, 32'h0000_2222);
    @(negedge clk);
    #1;
    chk("R9 drained", 32'(eff_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_pass();
    t_equal();
    t_modes();
    t_collide();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule